// File: doc/BRIEF.md
# Instruction Fetch and Bus-Cycle Sequencer

This block is the hardwired control core of a small accumulator machine. It owns the program counter, the instruction register, the operand address register, the accumulator and a return-address register. It walks every instruction through a fetch phase, a decode phase and an execute phase. The execute phase either finishes at once or starts one data transfer on a plain external memory bus. Slow devices can stretch any transfer by holding an active-low ready input high. While they do, the sequencer holds its bus outputs and all of its registers unchanged.

Instructions are 16-bit words. The opcode sits in bits [15:8]. Load, store, add, jump and jump-if-zero are followed by a second word that carries the operand address. Addition is done outside the block: the accumulator and the memory word are driven out on an ALU port, and the sum comes back on an input. A level interrupt request is taken only between instructions. Taking it saves the return address, masks further requests and restarts fetching at a fixed vector. The return-from-interrupt opcode restores the saved address.

Top module: `instr_seq_top`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, the block drives a read cycle (request high, read/write high) at the parameter RESET_ADDR. The accumulator clears to zero and the interrupt mask clears.
- R2: A fetch reads the word at the program counter and captures bits [15:8] as the opcode. The program counter then advances by one. The operand word of a two-word instruction is read the same way and also advances the counter.
- R3: Each instruction goes through fetch, then decode, then execute, in that order. LOAD (opcode 0x01) copies the word read at the operand address into the accumulator. ADD (0x03) reads the word at the operand address, drives alu_a with the accumulator, drives alu_b with the memory word and raises alu_en, then writes alu_res into the accumulator.
- R4: STORE (0x02) performs one write cycle at the operand address with the accumulator on the write-data bus. The read/write line is low only during a write cycle and is high at all other times.
- R5: JMP (0x04) continues fetching at the operand address. JZ (0x05) does the same only when the accumulator is zero; otherwise fetching continues at the word after the operand.
- R6: Any bus cycle with ready_n high is a wait cycle. In a wait cycle, request, address, read/write and write data stay unchanged and no register changes. The transfer completes on the first clock edge at which ready_n is low.
- R7: A request on irq_i that is high at an instruction boundary while unmasked is taken. irq_ack_o pulses for one cycle, the address of the next instruction is saved, the mask is set, and the next fetch reads at IRQ_VECTOR.
- R8: While the mask is set, irq_i is ignored. RETI (0x06) resumes fetching at the saved address and clears the mask. At least one instruction of the interrupted program completes before a still-pending request is taken again.
- R9: Any other opcode is a one-word instruction with no effect. The accumulator is unchanged, and the next fetch reads the following word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr_o | output | ADDR_W | Bus address |
| mem_wdata_o | output | DATA_W | Write data (accumulator during write cycles, zero otherwise) |
| mem_rdata_i | input | DATA_W | Read data |
| mem_rw_o | output | 1 | High for read, low for write |
| mem_req_o | output | 1 | A bus cycle is in progress |
| mem_ready_n_i | input | 1 | Active-low ready; high inserts a wait cycle |
| alu_a_o | output | DATA_W | Accumulator to the external adder |
| alu_b_o | output | DATA_W | Memory operand to the external adder |
| alu_en_o | output | 1 | Addition in progress |
| alu_res_i | input | DATA_W | Result from the external adder |
| irq_i | input | 1 | Level interrupt request |
| irq_ack_o | output | 1 | One-cycle pulse on interrupt entry |

## Verification
Some properties are checked on every cycle. These are the frozen bus during wait cycles, the idle-high read/write line, the reset fetch address, the vector fetch after each acknowledge, the fixed fetch-decode-execute order and the rule that entry never happens while masked. Other behaviour only the bench scenarios can show, by comparing every completed transfer in order against a computed list. That covers the accumulator values seen in written data, jump-if-zero taken and not taken, the effect-free unknown opcode, the saved return address, and a level request held through a whole service routine that re-enters only after one main instruction.

// File: rtl/seq_pkg.sv
package seq_pkg;

    localparam int OPC_W = 8;

    localparam logic [OPC_W-1:0] OP_LOAD  = 8'h01;
    localparam logic [OPC_W-1:0] OP_STORE = 8'h02;
    localparam logic [OPC_W-1:0] OP_ADD   = 8'h03;
    localparam logic [OPC_W-1:0] OP_JMP   = 8'h04;
    localparam logic [OPC_W-1:0] OP_JZ    = 8'h05;
    localparam logic [OPC_W-1:0] OP_RETI  = 8'h06;

    typedef enum logic [2:0] {
        PH_FETCH,
        PH_DECODE,
        PH_OPND,
        PH_EXEC,
        PH_DRD,
        PH_DWR,
        PH_INTR
    } phase_e;

    typedef enum logic {
        ASEL_PC,
        ASEL_MAR
    } asel_e;

    typedef struct packed {
        logic ld_ir;
        logic inc_pc;
        logic ld_pc_mar;
        logic ld_pc_vec;
        logic ld_pc_ret;
        logic ld_mar;
        logic ld_acc_mem;
        logic ld_acc_alu;
        logic save_ret;
        logic set_mask;
        logic clr_mask;
    } regctl_t;

    typedef struct packed {
        logic  req;
        logic  rd;
        asel_e asel;
    } busctl_t;

    function automatic logic has_operand(input logic [OPC_W-1:0] op);
        return (op == OP_LOAD) || (op == OP_STORE) || (op == OP_ADD) ||
               (op == OP_JMP)  || (op == OP_JZ);
    endfunction

endpackage

// File: rtl/seq_ctrl.sv
module seq_ctrl
    import seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [OPC_W-1:0] opcode_i,
    input  logic             acc_zero_i,
    input  logic             irq_i,
    input  logic             irq_mask_i,
    input  logic             ready_n_i,
    output regctl_t          ctl_o,
    output busctl_t          bus_o,
    output logic             alu_en_o,
    output logic             irq_ack_o
);

    phase_e state_q, state_d;
    logic   take_irq;

    assign take_irq = irq_i && !irq_mask_i;

    always_ff @(posedge clk) begin
        if (rst) state_q <= PH_FETCH;
        else     state_q <= state_d;
    end

    always_comb begin
        ctl_o     = '0;
        bus_o     = '{req: 1'b0, rd: 1'b1, asel: ASEL_PC};
        alu_en_o  = 1'b0;
        irq_ack_o = 1'b0;
        state_d   = state_q;
        unique case (state_q)
            PH_FETCH: begin
                bus_o = '{req: 1'b1, rd: 1'b1, asel: ASEL_PC};
                if (!ready_n_i) begin
                    ctl_o.ld_ir  = 1'b1;
                    ctl_o.inc_pc = 1'b1;
                    state_d      = PH_DECODE;
                end
            end
            PH_DECODE: begin
                state_d = has_operand(opcode_i) ? PH_OPND : PH_EXEC;
            end
            PH_OPND: begin
                bus_o = '{req: 1'b1, rd: 1'b1, asel: ASEL_PC};
                if (!ready_n_i) begin
                    ctl_o.ld_mar = 1'b1;
                    ctl_o.inc_pc = 1'b1;
                    state_d      = PH_EXEC;
                end
            end
            PH_EXEC: begin
                state_d = take_irq ? PH_INTR : PH_FETCH;
                if (opcode_i == OP_LOAD || opcode_i == OP_ADD) begin
                    state_d = PH_DRD;
                end else if (opcode_i == OP_STORE) begin
                    state_d = PH_DWR;
                end else if (opcode_i == OP_JMP) begin
                    ctl_o.ld_pc_mar = 1'b1;
                end else if (opcode_i == OP_JZ) begin
                    ctl_o.ld_pc_mar = acc_zero_i;
                end else if (opcode_i == OP_RETI) begin
                    ctl_o.ld_pc_ret = 1'b1;
                    ctl_o.clr_mask  = 1'b1;
                end
            end
            PH_DRD: begin
                bus_o    = '{req: 1'b1, rd: 1'b1, asel: ASEL_MAR};
                alu_en_o = (opcode_i == OP_ADD);
                if (!ready_n_i) begin
                    ctl_o.ld_acc_alu = (opcode_i == OP_ADD);
                    ctl_o.ld_acc_mem = (opcode_i != OP_ADD);
                    state_d          = take_irq ? PH_INTR : PH_FETCH;
                end
            end
            PH_DWR: begin
                bus_o = '{req: 1'b1, rd: 1'b0, asel: ASEL_MAR};
                if (!ready_n_i) begin
                    state_d = take_irq ? PH_INTR : PH_FETCH;
                end
            end
            PH_INTR: begin
                ctl_o.save_ret  = 1'b1;
                ctl_o.ld_pc_vec = 1'b1;
                ctl_o.set_mask  = 1'b1;
                irq_ack_o       = 1'b1;
                state_d         = PH_FETCH;
            end
            default: state_d = PH_FETCH;
        endcase
    end

    a_r2_decode_follows_fetch: assert property (@(posedge clk) disable iff (rst)
        state_q == PH_DECODE |-> $past(state_q) == PH_FETCH);

    a_r3_exec_follows_decode: assert property (@(posedge clk) disable iff (rst)
        state_q == PH_EXEC |-> ($past(state_q) == PH_DECODE || $past(state_q) == PH_OPND));

    a_r8_entry_unmasked: assert property (@(posedge clk) disable iff (rst)
        state_q == PH_INTR |-> !irq_mask_i);

endmodule

// File: rtl/seq_regs.sv
module seq_regs
    import seq_pkg::*;
#(
    parameter int              DATA_W     = 16,
    parameter int              ADDR_W     = 16,
    parameter logic [ADDR_W-1:0] RESET_ADDR = 16'h0010,
    parameter logic [ADDR_W-1:0] IRQ_VECTOR = 16'h0080
) (
    input  logic              clk,
    input  logic              rst,
    input  regctl_t           ctl_i,
    input  logic [DATA_W-1:0] rdata_i,
    input  logic [DATA_W-1:0] alu_res_i,
    output logic [ADDR_W-1:0] pc_o,
    output logic [ADDR_W-1:0] mar_o,
    output logic [DATA_W-1:0] acc_o,
    output logic [OPC_W-1:0]  opcode_o,
    output logic              acc_zero_o,
    output logic              irq_mask_o
);

    localparam int OPC_LSB = DATA_W - OPC_W;

    logic [ADDR_W-1:0] pc_q, mar_q, ret_q;
    logic [DATA_W-1:0] acc_q;
    logic [OPC_W-1:0]  ir_q;
    logic              mask_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= RESET_ADDR;
        end else if (ctl_i.ld_pc_vec) begin
            pc_q <= IRQ_VECTOR;
        end else if (ctl_i.ld_pc_ret) begin
            pc_q <= ret_q;
        end else if (ctl_i.ld_pc_mar) begin
            pc_q <= mar_q;
        end else if (ctl_i.inc_pc) begin
            pc_q <= pc_q + ADDR_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ir_q   <= '0;
            mar_q  <= '0;
            ret_q  <= '0;
            acc_q  <= '0;
            mask_q <= 1'b0;
        end else begin
            if (ctl_i.ld_ir)      ir_q  <= rdata_i[DATA_W-1:OPC_LSB];
            if (ctl_i.ld_mar)     mar_q <= rdata_i[ADDR_W-1:0];
            if (ctl_i.save_ret)   ret_q <= pc_q;
            if (ctl_i.ld_acc_mem) acc_q <= rdata_i;
            if (ctl_i.ld_acc_alu) acc_q <= alu_res_i;
            if (ctl_i.set_mask)   mask_q <= 1'b1;
            else if (ctl_i.clr_mask) mask_q <= 1'b0;
        end
    end

    assign pc_o       = pc_q;
    assign mar_o      = mar_q;
    assign acc_o      = acc_q;
    assign opcode_o   = ir_q;
    assign acc_zero_o = (acc_q == '0);
    assign irq_mask_o = mask_q;

    a_r5_one_pc_source: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ctl_i.inc_pc, ctl_i.ld_pc_mar, ctl_i.ld_pc_vec, ctl_i.ld_pc_ret}));

    a_r8_return_restores: assert property (@(posedge clk) disable iff (rst)
        ctl_i.ld_pc_ret |=> !mask_q);

endmodule

// File: rtl/seq_busmux.sv
module seq_busmux
    import seq_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 16
) (
    input  busctl_t           bus_i,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [ADDR_W-1:0] mar_i,
    input  logic [DATA_W-1:0] acc_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] wdata_o,
    output logic              rw_o,
    output logic              req_o
);

    logic is_write;

    assign is_write = bus_i.req && !bus_i.rd;
    assign addr_o   = (bus_i.asel == ASEL_MAR) ? mar_i : pc_i;
    assign wdata_o  = is_write ? acc_i : '0;
    assign rw_o     = !is_write;
    assign req_o    = bus_i.req;

endmodule

// File: rtl/instr_seq_top.sv
module instr_seq_top
    import seq_pkg::*;
#(
    parameter int                DATA_W     = 16,
    parameter int                ADDR_W     = 16,
    parameter logic [ADDR_W-1:0] RESET_ADDR = 16'h0010,
    parameter logic [ADDR_W-1:0] IRQ_VECTOR = 16'h0080
) (
    input  logic              clk,
    input  logic              rst,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic              mem_rw_o,
    output logic              mem_req_o,
    input  logic              mem_ready_n_i,
    output logic [DATA_W-1:0] alu_a_o,
    output logic [DATA_W-1:0] alu_b_o,
    output logic              alu_en_o,
    input  logic [DATA_W-1:0] alu_res_i,
    input  logic              irq_i,
    output logic              irq_ack_o
);

    regctl_t           ctl;
    busctl_t           bus;
    logic [ADDR_W-1:0] pc, mar;
    logic [DATA_W-1:0] acc;
    logic [OPC_W-1:0]  opcode;
    logic              acc_zero, irq_mask;

    seq_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .opcode_i   (opcode),
        .acc_zero_i (acc_zero),
        .irq_i      (irq_i),
        .irq_mask_i (irq_mask),
        .ready_n_i  (mem_ready_n_i),
        .ctl_o      (ctl),
        .bus_o      (bus),
        .alu_en_o   (alu_en_o),
        .irq_ack_o  (irq_ack_o)
    );

    seq_regs #(
        .DATA_W     (DATA_W),
        .ADDR_W     (ADDR_W),
        .RESET_ADDR (RESET_ADDR),
        .IRQ_VECTOR (IRQ_VECTOR)
    ) u_regs (
        .clk        (clk),
        .rst        (rst),
        .ctl_i      (ctl),
        .rdata_i    (mem_rdata_i),
        .alu_res_i  (alu_res_i),
        .pc_o       (pc),
        .mar_o      (mar),
        .acc_o      (acc),
        .opcode_o   (opcode),
        .acc_zero_o (acc_zero),
        .irq_mask_o (irq_mask)
    );

    seq_busmux #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_bus (
        .bus_i   (bus),
        .pc_i    (pc),
        .mar_i   (mar),
        .acc_i   (acc),
        .addr_o  (mem_addr_o),
        .wdata_o (mem_wdata_o),
        .rw_o    (mem_rw_o),
        .req_o   (mem_req_o)
    );

    assign alu_a_o = acc;
    assign alu_b_o = mem_rdata_i;

    a_r1_reset_fetch: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (mem_req_o && mem_rw_o && mem_addr_o == RESET_ADDR));

    a_r6_wait_holds_bus: assert property (@(posedge clk) disable iff (rst)
        (mem_req_o && mem_ready_n_i) |=>
            (mem_req_o && $stable(mem_addr_o) && $stable(mem_rw_o) && $stable(mem_wdata_o)));

    a_r4_rw_idles_high: assert property (@(posedge clk) disable iff (rst)
        !mem_req_o |-> mem_rw_o);

    a_r7_vector_fetch: assert property (@(posedge clk) disable iff (rst)
        irq_ack_o |=> (mem_req_o && mem_rw_o && mem_addr_o == IRQ_VECTOR));

endmodule

// File: tb/test_instr_seq_top.sv
module test_instr_seq_top;

    localparam logic [15:0] RST_A = 16'h0010;
    localparam logic [15:0] VEC_A = 16'h0080;
    localparam int K_RD = 0, K_WR = 1, K_ACK = 2;

    typedef struct {
        int          kind;
        logic [15:0] addr;
        logic [15:0] data;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] mem_addr, mem_wdata, mem_rdata, alu_a, alu_b, alu_res;
    logic        mem_rw, mem_req, alu_en, irq_ack;
    logic        ready_n = 1'b1;
    logic        irq = 1'b0;
    logic [15:0] mem [0:1023];

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done   = 0;

    always #5 clk = ~clk;

    instr_seq_top #(.DATA_W(16), .ADDR_W(16), .RESET_ADDR(RST_A), .IRQ_VECTOR(VEC_A)) i_instr_seq_top (
        .clk           (clk),
        .rst           (rst),
        .mem_addr_o    (mem_addr),
        .mem_wdata_o   (mem_wdata),
        .mem_rdata_i   (mem_rdata),
        .mem_rw_o      (mem_rw),
        .mem_req_o     (mem_req),
        .mem_ready_n_i (ready_n),
        .alu_a_o       (alu_a),
        .alu_b_o       (alu_b),
        .alu_en_o      (alu_en),
        .alu_res_i     (alu_res),
        .irq_i         (irq),
        .irq_ack_o     (irq_ack)
    );

    assign mem_rdata = mem[mem_addr[9:0]];
    assign alu_res   = alu_en ? (alu_a + alu_b) : 16'h0000;

    always @(posedge clk) begin
        if (mem_req && !mem_rw && !ready_n) mem[mem_addr[9:0]] <= mem_wdata;
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic exp_rd(input logic [15:0] a, input string tag);
        q.push_back('{kind: K_RD, addr: a, data: 16'h0, tag: tag});
    endtask

    task automatic exp_wr(input logic [15:0] a, input logic [15:0] d, input string tag);
        q.push_back('{kind: K_WR, addr: a, data: d, tag: tag});
    endtask

    task automatic exp_ack(input string tag);
        q.push_back('{kind: K_ACK, addr: 16'h0, data: 16'h0, tag: tag});
    endtask

    task automatic drain();
        while (q.size() != 0) @(posedge clk);
        repeat (4) @(posedge clk);
        #1;
    endtask

    // Monitor: decides ready_n, inserts waits, compares completed transfers.
    bit          in_cycle  = 0;
    int          wait_left = 0;
    int          xfer_n    = 0;
    logic [15:0] held_addr;
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (irq_ack) begin
                if (q.size() == 0) check(0, "R7", "unexpected acknowledge", 16'h1, 16'h0);
                else begin
                    check(q[0].kind == K_ACK, q[0].tag, "acknowledge where transfer expected",
                          16'(q[0].kind), 16'(K_ACK));
                    void'(q.pop_front());
                end
            end
            if (mem_req) begin
                if (!in_cycle) begin
                    in_cycle  = 1;
                    held_addr = mem_addr;
                    wait_left = (xfer_n % 4 == 1) ? 2 : 0;
                end else begin
                    check(mem_addr == held_addr, "R6", "address moved in wait", mem_addr, held_addr);
                end
                if (wait_left > 0) begin
                    wait_left--;
                    ready_n = 1'b1;
                end else if (q.size() == 0) begin
                    ready_n = 1'b1;
                end else begin
                    if (q[0].kind == K_ACK) begin
                        check(0, q[0].tag, "bus cycle where acknowledge expected", mem_addr, 16'h0);
                    end else begin
                        check(mem_rw == (q[0].kind == K_RD), q[0].tag, "read/write line",
                              16'(mem_rw), 16'(q[0].kind == K_RD));
                        check(mem_addr == q[0].addr, q[0].tag, "bus address", mem_addr, q[0].addr);
                        if (q[0].kind == K_WR)
                            check(mem_wdata == q[0].data, q[0].tag, "write data", mem_wdata, q[0].data);
                    end
                    void'(q.pop_front());
                    ready_n  = 1'b0;
                    in_cycle = 0;
                    xfer_n++;
                end
            end else begin
                check(mem_rw == 1'b1, "R4", "read/write low while idle", 16'(mem_rw), 16'h1);
                ready_n = 1'b1;
            end
        end
    end

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = 16'h0000;
        mem[16'h10] = 16'h0100; mem[16'h11] = 16'h0200;
        mem[16'h12] = 16'h0300; mem[16'h13] = 16'h0201;
        mem[16'h14] = 16'h0900;
        mem[16'h15] = 16'h0200; mem[16'h16] = 16'h0300;
        mem[16'h17] = 16'h0500; mem[16'h18] = 16'h0040;
        mem[16'h19] = 16'h0400; mem[16'h1A] = 16'h0020;
        mem[16'h20] = 16'h0100; mem[16'h21] = 16'h0202;
        mem[16'h22] = 16'h0500; mem[16'h23] = 16'h0030;
        mem[16'h30] = 16'h0200; mem[16'h31] = 16'h0301;
        mem[16'h32] = 16'h0400; mem[16'h33] = 16'h0032;
        mem[16'h80] = 16'h0100; mem[16'h81] = 16'h0200;
        mem[16'h82] = 16'h0300; mem[16'h83] = 16'h0201;
        mem[16'h84] = 16'h0200; mem[16'h85] = 16'h0302;
        mem[16'h86] = 16'h0600;
        mem[16'h200] = 16'h0005; mem[16'h201] = 16'h0003; mem[16'h202] = 16'h0000;
        mem[16'h301] = 16'hFFFF;

        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1: reset state on the bus
        check(mem_req == 1'b1, "R1", "request after reset", 16'(mem_req), 16'h1);
        check(mem_rw == 1'b1, "R1", "read after reset", 16'(mem_rw), 16'h1);
        check(mem_addr == RST_A, "R1", "reset fetch address", mem_addr, RST_A);
        check(irq_ack == 1'b0, "R1", "acknowledge after reset", 16'(irq_ack), 16'h0);
        @(posedge clk); #1;

        exp_rd(16'h10, "R2"); exp_rd(16'h11, "R2"); exp_rd(16'h200, "R3");
        exp_rd(16'h12, "R3"); exp_rd(16'h13, "R3"); exp_rd(16'h201, "R3");
        exp_rd(16'h14, "R9");
        exp_rd(16'h15, "R9"); exp_rd(16'h16, "R4"); exp_wr(16'h300, 16'h0008, "R3");
        exp_rd(16'h17, "R5"); exp_rd(16'h18, "R5");
        exp_rd(16'h19, "R5"); exp_rd(16'h1A, "R5");
        exp_rd(16'h20, "R5"); exp_rd(16'h21, "R2"); exp_rd(16'h202, "R3");
        exp_rd(16'h22, "R5"); exp_rd(16'h23, "R5");
        exp_rd(16'h30, "R5"); exp_rd(16'h31, "R4"); exp_wr(16'h301, 16'h0000, "R4");
        exp_rd(16'h32, "R5"); exp_rd(16'h33, "R5");
        drain();
        check(mem[16'h301] == 16'h0000, "R4", "stored word in memory", mem[16'h301], 16'h0000);

        // Level request raised while stalled in the fetch after a boundary.
        irq = 1'b1;
        exp_rd(16'h32, "R7"); exp_rd(16'h33, "R7"); exp_ack("R7");
        exp_rd(16'h80, "R7"); exp_rd(16'h81, "R8"); exp_rd(16'h200, "R8");
        exp_rd(16'h82, "R8"); exp_rd(16'h83, "R8"); exp_rd(16'h201, "R8");
        exp_rd(16'h84, "R8"); exp_rd(16'h85, "R8"); exp_wr(16'h302, 16'h0008, "R8");
        exp_rd(16'h86, "R8");
        exp_rd(16'h32, "R8"); exp_rd(16'h33, "R8"); exp_ack("R8");
        exp_rd(16'h80, "R7");
        drain();
        irq = 1'b0;
        exp_rd(16'h81, "R7"); exp_rd(16'h200, "R7");
        exp_rd(16'h82, "R7"); exp_rd(16'h83, "R7"); exp_rd(16'h201, "R7");
        exp_rd(16'h84, "R7"); exp_rd(16'h85, "R7"); exp_wr(16'h302, 16'h0008, "R7");
        exp_rd(16'h86, "R8");
        exp_rd(16'h32, "R8"); exp_rd(16'h33, "R8");
        exp_rd(16'h32, "R8"); exp_rd(16'h33, "R8");
        drain();

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired with %0d items pending actual=%0d expected=0",
                     q.size(), q.size());
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule